// File: doc/BRIEF.md
# Serial Clock-Control Register Interface

This block is the control front end of a multi-output audio clock generator that runs from a master clock. It decides which sampling-frequency group and rate the synthesizers target, which multiplier each rate-dependent output uses, and which of the six clock outputs are driven. Settings come from one of two sources that share the same three pins. In software mode the pins carry a three-wire serial stream: a shift clock, a data line and a latch strobe. In hardware mode the same pins are static straps that select the group and the rate directly. A separate mode pin chooses between the two sources.

All pins are brought into the master-clock domain through two-flop synchronizers. A reset sequencer holds the block in its default state while the external reset is low or a power-on request is present. It then keeps the block in that state for a fixed number of master clocks after the request goes away. The block also emits a one-cycle pulse whenever the active group or rate changes, so downstream logic can start a settling interval.

Top module: `clkgen_ctl`

## Requirements
- R1: In software mode, each rising edge of the shift clock shifts the data line into the control word, most significant bit first. When more than 16 bits arrive before a latch, the last 16 bits form the word.
- R2: A rising edge of the latch strobe commits the word only when at least 16 bits have been shifted since the last falling edge of the strobe, and a latch that comes long after the last shift clock is still accepted. A latch that arrives after fewer bits is ignored. The bit count clears on each falling edge of the strobe.
- R3: The control word has these fields: bits 1:0 are the group code, bits 3:2 are the rate code, and bits 9:4 are the output enables. Word bit 4+i drives `out_en[i]`, where i=0..3 are outputs 1 to 4, i=4 is the inverted master clock and i=5 is the master clock. A 1 enables the output.
- R4: The group code maps 00 to 48 kHz (`grp_sel`=0), 01 to 44.1 kHz (1) and 10 to 32 kHz (2). The rate code maps 00 to standard rate and 01 to double rate (`dbl_rate`=1). A reserved code (group 11, or rate 10 or 11) leaves its field unchanged, while the other fields of the same word still update.
- R5: While the mode pin is high, the group comes from {`io_sck_g1`,`io_dat_g0`} using the encoding of R4, and `io_stb_r0` high selects double rate. A reserved group code keeps the last group. All six enables are 1, and no serial word is committed.
- R6: Reset loads the 48 kHz group, standard rate and all enables on. While `rst_busy` is high, the outputs show exactly these defaults.
- R7: `rst_busy` is high while `ext_rst_n` is low or `por_req` is high. It stays high through the 1024th rising clock edge after the request ends, and is low after that edge.
- R8: `mult_o2` is 256 and `mult_o3` is 384. `mult_o4` is 768 at standard rate and 384 at double rate.
- R9: `rate_hz` gives the active sampling rate in hertz: the group base (48000, 44100 or 32000), doubled at double rate.
- R10: `cfg_changed` is high for exactly the cycles in which `grp_sel` or `dbl_rate` took a new value at the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| por_req | input | 1 | Power-on reset request, active high |
| ext_rst_n | input | 1 | External reset, active low |
| io_hw_sel | input | 1 | Mode pin: 1 = hardware straps, 0 = serial |
| io_stb_r0 | input | 1 | Latch strobe (serial) / rate strap (hardware) |
| io_dat_g0 | input | 1 | Serial data / group strap bit 0 |
| io_sck_g1 | input | 1 | Shift clock / group strap bit 1 |
| rst_busy | output | 1 | Internal reset active |
| grp_sel | output | 2 | Active sampling-frequency group |
| dbl_rate | output | 1 | Active rate: 1 = double |
| out_en | output | 6 | Per-output enables |
| mult_o2 | output | 10 | Rate multiplier of output 2 |
| mult_o3 | output | 10 | Rate multiplier of output 3 |
| mult_o4 | output | 10 | Rate multiplier of output 4 |
| rate_hz | output | 17 | Active sampling rate in hertz |
| cfg_changed | output | 1 | One-cycle pulse on a group or rate change |

## Verification
A behavioural model tracks the pins through a history queue and is compared with every output on every clock. It is driven with several kinds of serial traffic. A word whose bit order tells MSB-first from LSB-first shows the shift direction. A short burst followed by a latch shows that the bit count gates the commit, a 17-bit burst shows that the oldest bit is dropped, and a latch delayed by hundreds of cycles shows that late latches are accepted. Words that carry one reserved field next to valid fields show that fields update independently. Strap changes in hardware mode, including a reserved group and a serial burst sent while the straps are active, show which source wins. The first cycle of each reset release, for both the external reset and the power-on request, checks the exact 1024-edge count.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  localparam int WORD_W = 16;
  localparam int N_OUT  = 6;
  localparam int FS_LSB = 0;
  localparam int SR_LSB = 2;
  localparam int CE_LSB = 4;
  localparam int MULT_W = 10;
  localparam int RATE_W = 17;

  typedef enum logic [1:0] {
    GRP_48K  = 2'b00,
    GRP_44K1 = 2'b01,
    GRP_32K  = 2'b10,
    GRP_RSV  = 2'b11
  } grp_e;

  // Base rate of a group, doubled when double rate is active.
  function automatic logic [RATE_W-1:0] rate_of(input grp_e g, input logic dbl);
    int base;
    case (g)
      GRP_44K1: base = 44100;
      GRP_32K:  base = 32000;
      default:  base = 48000;
    endcase
    return dbl ? RATE_W'(base * 2) : RATE_W'(base);
  endfunction

  // Multiplier of an output index (2..4); output 1 is fixed and reports 0.
  function automatic logic [MULT_W-1:0] mult_of(input int idx, input logic dbl);
    case (idx)
      2:       return MULT_W'(256);
      3:       return MULT_W'(384);
      4:       return dbl ? MULT_W'(384) : MULT_W'(768);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/clkgen_sync.sv
module clkgen_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    meta <= d;
    q    <= meta;
  end
endmodule

// File: rtl/clkgen_rst_seq.sv
module clkgen_rst_seq #(
  parameter int RST_CYCLES = 1024
) (
  input  logic clk,
  input  logic por_req,
  input  logic ext_rst_n,
  output logic busy
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt;
  logic          hold_req;

  assign hold_req = !ext_rst_n || por_req;

  always_ff @(posedge clk) begin
    if (hold_req) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy) begin
      if (cnt == CW'(RST_CYCLES - 1)) busy <= 1'b0;
      else                            cnt  <= cnt + 1'b1;
    end
  end

  // R7: a pending request keeps the sequencer busy
  assert_hold_R7: assert property (@(posedge clk) disable iff (por_req)
    !ext_rst_n |=> busy);

  // R7: release happens only at the end of the full count
  assert_release_R7: assert property (@(posedge clk) disable iff (hold_req)
    $fell(busy) |-> ($past(cnt) == CW'(RST_CYCLES - 1)));
endmodule

// File: rtl/clkgen_serial_rx.sv
module clkgen_serial_rx #(
  parameter int WORD_W = 16,
  parameter int KEEP_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck_s,
  input  logic              stb_s,
  input  logic              dat_s,
  output logic              word_ok,
  output logic [KEEP_W-1:0] word_lo
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic             sck_d, stb_d;
  logic             sck_rise, stb_rise, stb_fall;
  logic [CNT_W-1:0] bit_cnt;
  logic             full;

  always_ff @(posedge clk) begin
    sck_d <= sck_s;
    stb_d <= stb_s;
  end

  assign sck_rise = sck_s & ~sck_d;
  assign stb_rise = stb_s & ~stb_d;
  assign stb_fall = ~stb_s & stb_d;
  assign full     = (bit_cnt == CNT_W'(WORD_W));

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt <= '0;
      word_lo <= '0;
    end else begin
      if (stb_fall)                bit_cnt <= '0;
      else if (sck_rise && !full) bit_cnt <= bit_cnt + 1'b1;
      if (sck_rise) word_lo <= {word_lo[KEEP_W-2:0], dat_s};
    end
  end

  assign word_ok = stb_rise & full;

  // R1: the bit count saturates at the word length
  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(WORD_W));

  // R2: a strobe falling edge restarts the count
  assert_cnt_clear_R2: assert property (@(posedge clk) disable iff (rst)
    stb_fall |=> (bit_cnt == '0));
endmodule

// File: rtl/clkgen_ctl.sv
module clkgen_ctl
  import clkgen_pkg::*;
#(
  parameter int RST_CYCLES = 1024
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic              ext_rst_n,
  input  logic              io_hw_sel,
  input  logic              io_stb_r0,
  input  logic              io_dat_g0,
  input  logic              io_sck_g1,
  output logic              rst_busy,
  output logic [1:0]        grp_sel,
  output logic              dbl_rate,
  output logic [N_OUT-1:0]  out_en,
  output logic [MULT_W-1:0] mult_o2,
  output logic [MULT_W-1:0] mult_o3,
  output logic [MULT_W-1:0] mult_o4,
  output logic [RATE_W-1:0] rate_hz,
  output logic              cfg_changed
);
  localparam int KEEP_W = CE_LSB + N_OUT;

  logic [3:0]        pins_s;
  logic              hw_s, a_s, b_s, c_s;
  logic              word_ok, commit;
  logic [KEEP_W-1:0] word_lo;
  grp_e              fs_r, src_grp, nxt_grp, grp_q;
  logic              dbl_r, src_dbl, dbl_q;
  logic [N_OUT-1:0]  ce_r;

  clkgen_sync #(.W(4)) u_sync (
    .clk (clk),
    .d   ({io_hw_sel, io_stb_r0, io_dat_g0, io_sck_g1}),
    .q   (pins_s)
  );

  assign {hw_s, a_s, b_s, c_s} = pins_s;

  clkgen_rst_seq #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk       (clk),
    .por_req   (por_req),
    .ext_rst_n (ext_rst_n),
    .busy      (rst_busy)
  );

  clkgen_serial_rx #(.WORD_W(WORD_W), .KEEP_W(KEEP_W)) u_rx (
    .clk     (clk),
    .rst     (rst_busy),
    .sck_s   (c_s),
    .stb_s   (a_s),
    .dat_s   (b_s),
    .word_ok (word_ok),
    .word_lo (word_lo)
  );

  assign commit = word_ok & ~hw_s;

  // Mode register: reserved codes leave their own field untouched.
  always_ff @(posedge clk) begin
    if (rst_busy) begin
      fs_r  <= GRP_48K;
      dbl_r <= 1'b0;
      ce_r  <= '1;
    end else if (commit) begin
      if (word_lo[FS_LSB +: 2] != GRP_RSV) fs_r <= grp_e'(word_lo[FS_LSB +: 2]);
      if (!word_lo[SR_LSB + 1])           dbl_r <= word_lo[SR_LSB];
      ce_r <= word_lo[CE_LSB +: N_OUT];
    end
  end

  assign src_grp = hw_s ? grp_e'({c_s, b_s}) : fs_r;
  assign src_dbl = hw_s ? a_s : dbl_r;
  assign nxt_grp = (src_grp == GRP_RSV) ? grp_q : src_grp;

  always_ff @(posedge clk) begin
    if (rst_busy) begin
      grp_q       <= GRP_48K;
      dbl_q       <= 1'b0;
      cfg_changed <= 1'b0;
    end else begin
      grp_q       <= nxt_grp;
      dbl_q       <= src_dbl;
      cfg_changed <= (nxt_grp != grp_q) || (src_dbl != dbl_q);
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < N_OUT; gi++) begin : g_en
      assign out_en[gi] = rst_busy | hw_s | ce_r[gi];
    end
  endgenerate

  assign grp_sel  = grp_q;
  assign dbl_rate = dbl_q;
  assign mult_o2  = mult_of(2, dbl_q);
  assign mult_o3  = mult_of(3, dbl_q);
  assign mult_o4  = mult_of(4, dbl_q);
  assign rate_hz  = rate_of(grp_q, dbl_q);

  // R4: a reserved group code in a committed word keeps the stored group
  assert_rsv_group_R4: assert property (@(posedge clk) disable iff (rst_busy)
    (commit && word_lo[FS_LSB +: 2] == 2'b11) |=> $stable(fs_r));

  // R5: with the straps active, the enable register never moves
  assert_hw_lock_R5: assert property (@(posedge clk) disable iff (rst_busy)
    $past(hw_s) |-> $stable(ce_r));

  // R10: the change pulse matches an actual move of group or rate
  assert_chg_pulse_R10: assert property (@(posedge clk) disable iff (rst_busy)
    cfg_changed == ((grp_q != $past(grp_q)) || (dbl_q != $past(dbl_q))));

  // R8: output 4 runs at twice output 3 only at standard rate
  assert_mult_pair_R8: assert property (@(posedge clk) disable iff (rst_busy)
    mult_o4 == (dbl_q ? mult_o3 : {mult_o3[MULT_W-2:0], 1'b0}));
endmodule

// File: tb/clkgen_ctl_bench.sv
module clkgen_ctl_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic por_req = 1'b0, ext_rst_n = 1'b0;
  logic hw = 1'b0, pa = 1'b0, pb = 1'b0, pc = 1'b0;

  logic        rst_busy, dbl_rate, cfg_changed;
  logic [1:0]  grp_sel;
  logic [5:0]  out_en;
  logic [9:0]  mult_o2, mult_o3, mult_o4;
  logic [16:0] rate_hz;

  clkgen_ctl u_clkgen_ctl (
    .clk(clk), .por_req(por_req), .ext_rst_n(ext_rst_n),
    .io_hw_sel(hw), .io_stb_r0(pa), .io_dat_g0(pb), .io_sck_g1(pc),
    .rst_busy(rst_busy), .grp_sel(grp_sel), .dbl_rate(dbl_rate),
    .out_en(out_en), .mult_o2(mult_o2), .mult_o3(mult_o3),
    .mult_o4(mult_o4), .rate_hz(rate_hz), .cfg_changed(cfg_changed)
  );

  int n_chk = 0, n_err = 0, pulses = 0;

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int ref_rate(input int g, input int d);
    int base = (g == 1) ? 44100 : (g == 2) ? 32000 : 48000;
    return d ? 2 * base : base;
  endfunction

  // Behavioural reference, advanced on every rising edge.
  int m_busy = 1, m_rcnt = 0, m_bits = 0, m_word = 0;
  int m_fs = 0, m_dbl_r = 0, m_ce = 63, m_grp = 0, m_dbl = 0, m_chg = 0;
  int cycles = 0;
  logic [3:0] hist[$];

  always @(posedge clk) begin : model
    logic [3:0] cur, prv;
    int obusy, src, ng, nd, w;
    bit sck_r, stb_r, stb_f, commit;
    cur = (hist.size() >= 2) ? hist[hist.size()-2] : 4'b0;
    prv = (hist.size() >= 3) ? hist[hist.size()-3] : 4'b0;
    obusy = m_busy;
    if (!ext_rst_n || por_req) begin
      m_busy = 1; m_rcnt = 0;
    end else if (m_busy != 0) begin
      m_rcnt++;
      if (m_rcnt == 1024) m_busy = 0;
    end
    if (obusy != 0) begin
      m_bits = 0; m_word = 0; m_fs = 0; m_dbl_r = 0; m_ce = 63;
      m_grp = 0; m_dbl = 0; m_chg = 0;
    end else begin
      sck_r = cur[0] && !prv[0];
      stb_r = cur[2] && !prv[2];
      stb_f = !cur[2] && prv[2];
      commit = stb_r && (m_bits == 16) && !cur[3];
      w = m_word;
      src = cur[3] ? int'({cur[0], cur[1]}) : m_fs;
      ng = (src == 3) ? m_grp : src;
      nd = cur[3] ? int'(cur[2]) : m_dbl_r;
      m_chg = ((ng != m_grp) || (nd != m_dbl)) ? 1 : 0;
      m_grp = ng; m_dbl = nd;
      if (stb_f) m_bits = 0;
      else if (sck_r && m_bits < 16) m_bits++;
      if (sck_r) m_word = ((m_word << 1) | int'(cur[1])) & 16'hFFFF;
      if (commit) begin
        if ((w & 3) != 3) m_fs = w & 3;
        if (((w >> 2) & 3) < 2) m_dbl_r = (w >> 2) & 3;
        m_ce = (w >> 4) & 63;
      end
    end
    hist.push_back({hw, pa, pb, pc});
    if (hist.size() > 3) void'(hist.pop_front());
    cycles++;
  end

  always @(negedge clk) begin
    if (cfg_changed) pulses++;
    if (cycles >= 3) begin
      chk("R7", "rst_busy", rst_busy, m_busy);
      chk("R4", "grp_sel", grp_sel, m_grp);
      chk("R4", "dbl_rate", dbl_rate, m_dbl);
      chk("R3", "out_en", out_en, (m_busy != 0 || hist[1][3]) ? 63 : m_ce);
      chk("R8", "mult_o2", mult_o2, 256);
      chk("R8", "mult_o3", mult_o3, 384);
      chk("R8", "mult_o4", mult_o4, m_dbl ? 384 : 768);
      chk("R9", "rate_hz", rate_hz, ref_rate(m_grp, m_dbl));
      chk("R10", "cfg_changed", cfg_changed, m_chg);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [19:0] w, input int nbits, input int late);
    for (int i = nbits - 1; i >= 0; i--) begin
      pb = w[i]; tick(3);
      pc = 1'b1; tick(3);
      pc = 1'b0; tick(3);
    end
    tick(late);
    pa = 1'b1; tick(4);
    pa = 1'b0; tick(12);
  endtask

  task automatic expect_cfg(input string req, input int g, input int d, input int en);
    chk(req, "grp_sel", grp_sel, g);
    chk(req, "dbl_rate", dbl_rate, d);
    chk(req, "out_en", out_en, en);
    chk(req, "rate_hz", rate_hz, ref_rate(g, d));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : stim
    int p0;
    tick(10);
    expect_cfg("R6", 0, 0, 63);
    chk("R6", "rst_busy", rst_busy, 1);
    ext_rst_n = 1'b1;
    tick(1023);
    chk("R7", "busy at edge 1023", rst_busy, 1);
    tick(1);
    chk("R7", "busy after edge 1024", rst_busy, 0);
    expect_cfg("R6", 0, 0, 63);
    chk("R8", "mult_o4 standard", mult_o4, 768);

    // group 44.1k, double, enables 101010
    send(20'h002A5, 16, 0);
    expect_cfg("R3", 1, 1, 6'h2A);
    chk("R8", "mult_o4 double", mult_o4, 384);

    // short burst: ignored
    send(20'h000F3, 8, 0);
    expect_cfg("R2", 1, 1, 6'h2A);

    // reserved rate code 10 keeps double; group 32k, enables 000011
    send(20'h0003A, 16, 0);
    expect_cfg("R4", 2, 1, 6'h03);

    // reserved group code 11 keeps 32k; rate standard, all enables
    send(20'h003F3, 16, 0);
    expect_cfg("R4", 2, 0, 6'h3F);

    // MSB-first order, late latch
    send(20'h00191, 16, 200);
    expect_cfg("R1", 1, 0, 6'h19);
    chk("R2", "late latch grp", grp_sel, 1);

    // 17 bits: oldest dropped
    send(20'h10025, 17, 0);
    expect_cfg("R1", 1, 1, 6'h02);

    // hardware straps
    hw = 1'b1; pc = 1'b0; pb = 1'b0; pa = 1'b1;
    tick(8);
    expect_cfg("R5", 0, 1, 6'h3F);
    pc = 1'b1; pb = 1'b1; pa = 1'b0;
    tick(8);
    expect_cfg("R5", 0, 0, 6'h3F);
    pc = 1'b1; pb = 1'b0;
    tick(8);
    expect_cfg("R5", 2, 0, 6'h3F);
    p0 = pulses;
    pc = 1'b0; pb = 1'b1;
    tick(10);
    chk("R10", "pulses on one change", pulses - p0, 1);
    p0 = pulses;
    tick(10);
    chk("R10", "pulses when steady", pulses - p0, 0);
    send(20'h00000, 16, 0);
    expect_cfg("R5", 0, 0, 6'h3F);
    hw = 1'b0;
    tick(8);
    expect_cfg("R5", 1, 1, 6'h02);

    // power-on request
    por_req = 1'b1; tick(2); por_req = 1'b0;
    tick(1023);
    chk("R7", "por busy at edge 1023", rst_busy, 1);
    expect_cfg("R6", 0, 0, 63);
    tick(1);
    chk("R7", "por busy after edge 1024", rst_busy, 0);
    tick(4);
    expect_cfg("R6", 0, 0, 63);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule